// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which master drives a shared external bus. Up to six processor masters and one host compete for it. Each processor holds a request line high for as long as it wants the bus. The arbiter answers with a one-hot grant vector. The host has its own request and grant pair.

Ownership among processors is non-preemptive, and the owner is chosen by either fixed or rotating priority. A run-time mode input picks the scheme. A lock input lets the owner keep the bus across an indivisible read-modify-write. Any change of owner costs exactly one cycle with no grant active. When nobody requests, the last processor owner stays parked on the bus.

The controller is a five-state machine:
- `ST_IDLE`: no owner. Left for `ST_HOST` on a host request, or for `ST_OWN` on a processor request, with no gap cycle.
- `ST_OWN`: a processor owns the bus and is transferring. Stays while lock is high or while the owner keeps requesting. Goes to `ST_GAP` for the host once the transfer has ended, or to `ST_GAP` for another requester. Goes to `ST_PARK` when nobody requests.
- `ST_PARK`: the grant is held on the last owner. Goes back to `ST_OWN` when that owner requests again, or to `ST_GAP` when a different master wins.
- `ST_GAP`: the one changeover cycle. Goes to `ST_HOST` or `ST_OWN` for the pending winner.
- `ST_HOST`: the host owns the bus. Goes to `ST_GAP` when the host releases and processors wait, otherwise to `ST_IDLE`.

Top module: `mbus_arbiter`

## Requirements
- R1: At most one grant is active in any cycle across `proc_gnt` and `host_gnt`. `proc_gnt` is one-hot or zero, and bit i means processor i owns the bus.
- R2: With `rot_mode`=0 (fixed), the requesting processor with the lowest index wins.
- R3: With `rot_mode`=1 (rotating), the search starts at the index just above the last processor owner and wraps around, so the last owner has lowest priority.
- R4: `rot_mode` may change at any time. It applies at the next ownership decision.
- R5: When the grant moves from one master to a different one (host included), exactly one cycle with all grants low comes in between.
- R6: While `lock` is high and a processor grant is active, that grant does not change, whatever the other requests.
- R7: A host request is granted, after the R5 gap, once the owner has `lock` low and `busy` low, even if the owner still requests. The host outranks every processor request.
- R8: The host keeps `host_gnt` while `host_req` stays high. `host_gnt` drops in the cycle after `host_req` falls.
- R9: With no requests pending, the grant stays on the last processor owner. If that owner requests again, it continues with no gap cycle.
- R10: After reset all grants are low. From the no-owner state, the first grant (processor or host) is issued without a gap cycle.
- R11: A processor owner keeps the bus while its request stays high, even if higher-priority processors request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| proc_req | input | NPROC (6) | Bus request, one bit per processor |
| lock | input | 1 | Owner holds the bus indivisibly |
| busy | input | 1 | Owner's current transfer is still in progress |
| host_req | input | 1 | Host bus request |
| proc_gnt | output | NPROC (6) | One-hot processor grant |
| host_gnt | output | 1 | Host bus grant |

## Verification
On every cycle, the assertions check that grants are mutually exclusive and one-hot. They also check that any active grant either holds or falls to zero on the next cycle, which rules out a direct hand-over with no gap. Further checks cover a locked grant staying put and the host grant following its request. Only the directed scenarios can show which master wins under each priority mode, and that a mode change applies at the next decision. The same holds for parking without a gap, for the host waiting on a busy owner, and for the gap lasting exactly one cycle before the new grant appears.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OWN  = 3'd1,
        ST_PARK = 3'd2,
        ST_GAP  = 3'd3,
        ST_HOST = 3'd4
    } arb_state_t;

endpackage

// File: rtl/mbus_arb_pick.sv
// Priority selector: fixed (lowest index) or rotating (after last owner).
module mbus_arb_pick #(
    parameter int NPROC = 6,
    localparam int IDXW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic [NPROC-1:0] req,
    input  logic [IDXW-1:0]  last,
    input  logic             rot,
    output logic             any,
    output logic [IDXW-1:0]  win
);

    logic [IDXW-1:0] fix_idx;
    logic [IDXW-1:0] rot_idx;
    logic            fix_hit;
    logic            rot_hit;

    always_comb begin
        fix_idx = '0;
        fix_hit = 1'b0;
        for (int i = 0; i < NPROC; i++) begin
            if (!fix_hit && req[i]) begin
                fix_idx = IDXW'(i);
                fix_hit = 1'b1;
            end
        end
    end

    always_comb begin
        int cand;
        rot_idx = '0;
        rot_hit = 1'b0;
        for (int k = 1; k <= NPROC; k++) begin
            cand = (int'(last) + k) % NPROC;
            if (!rot_hit && req[cand]) begin
                rot_idx = IDXW'(cand);
                rot_hit = 1'b1;
            end
        end
    end

    assign any = fix_hit;
    assign win = rot ? rot_idx : fix_idx;

endmodule

// File: rtl/mbus_arb_ctrl.sv
// Ownership state machine.
module mbus_arb_ctrl
    import mbus_arb_pkg::*;
#(
    parameter int NPROC = 6,
    localparam int IDXW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] req,
    input  logic             lock,
    input  logic             busy,
    input  logic             host_req,
    input  logic             any_req,
    input  logic [IDXW-1:0]  win,
    output logic [IDXW-1:0]  owner,
    output logic             proc_on,
    output logic             host_on
);

    arb_state_t      state_q, state_d;
    logic [IDXW-1:0] owner_q, owner_d;
    logic [IDXW-1:0] pend_q,  pend_d;
    logic            phost_q, phost_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            pend_q  <= '0;
            phost_q <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            pend_q  <= pend_d;
            phost_q <= phost_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        pend_d  = pend_q;
        phost_d = phost_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    state_d = ST_HOST;
                end else if (any_req) begin
                    state_d = ST_OWN;
                    owner_d = win;
                end
            end
            ST_OWN: begin
                if (lock) begin
                    state_d = ST_OWN;
                end else if (host_req && !busy) begin
                    state_d = ST_GAP;
                    phost_d = 1'b1;
                end else if (req[owner_q]) begin
                    state_d = ST_OWN;
                end else if (any_req) begin
                    state_d = ST_GAP;
                    phost_d = 1'b0;
                    pend_d  = win;
                end else begin
                    state_d = ST_PARK;
                end
            end
            ST_PARK: begin
                if (lock) begin
                    state_d = req[owner_q] ? ST_OWN : ST_PARK;
                end else if (host_req) begin
                    state_d = ST_GAP;
                    phost_d = 1'b1;
                end else if (any_req && win == owner_q) begin
                    state_d = ST_OWN;
                end else if (any_req) begin
                    state_d = ST_GAP;
                    phost_d = 1'b0;
                    pend_d  = win;
                end
            end
            ST_GAP: begin
                if (phost_q) begin
                    state_d = ST_HOST;
                end else begin
                    state_d = ST_OWN;
                    owner_d = pend_q;
                end
            end
            ST_HOST: begin
                if (!host_req) begin
                    if (any_req) begin
                        state_d = ST_GAP;
                        phost_d = 1'b0;
                        pend_d  = win;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        proc_on = (state_q == ST_OWN) || (state_q == ST_PARK);
        host_on = (state_q == ST_HOST);
        owner   = owner_q;
    end

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter #(
    parameter int NPROC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rot_mode,
    input  logic [NPROC-1:0] proc_req,
    input  logic             lock,
    input  logic             busy,
    input  logic             host_req,
    output logic [NPROC-1:0] proc_gnt,
    output logic             host_gnt
);

    localparam int IDXW = (NPROC > 1) ? $clog2(NPROC) : 1;

    logic            any_req;
    logic [IDXW-1:0] win;
    logic [IDXW-1:0] owner;
    logic            proc_on;

    mbus_arb_pick #(.NPROC(NPROC)) u_pick (
        .req  (proc_req),
        .last (owner),
        .rot  (rot_mode),
        .any  (any_req),
        .win  (win)
    );

    mbus_arb_ctrl #(.NPROC(NPROC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (proc_req),
        .lock     (lock),
        .busy     (busy),
        .host_req (host_req),
        .any_req  (any_req),
        .win      (win),
        .owner    (owner),
        .proc_on  (proc_on),
        .host_on  (host_gnt)
    );

    for (genvar g = 0; g < NPROC; g++) begin : g_gnt
        assign proc_gnt[g] = proc_on && (owner == IDXW'(g));
    end

endmodule

// File: rtl/mbus_arb_checks.sv
module mbus_arb_checks #(
    parameter int NPROC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock,
    input logic             host_req,
    input logic [NPROC-1:0] proc_gnt,
    input logic             host_gnt
);

    logic [NPROC:0] all_gnt;
    assign all_gnt = {host_gnt, proc_gnt};

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_gnt)); // R1

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|all_gnt) |=> (all_gnt == $past(all_gnt) || all_gnt == '0)); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|proc_gnt && lock) |=> (proc_gnt == $past(proc_gnt))); // R6

    AST_HOST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && host_req) |=> host_gnt); // R8

    AST_HOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !host_req) |=> !host_gnt); // R8

endmodule

bind mbus_arbiter mbus_arb_checks #(.NPROC(NPROC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (lock),
    .host_req (host_req),
    .proc_gnt (proc_gnt),
    .host_gnt (host_gnt)
);

// File: tb/mbus_arbiter_tb.sv
module mbus_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rot_mode = 1'b0;
    logic [5:0] proc_req = '0;
    logic       lock = 1'b0;
    logic       busy = 1'b0;
    logic       host_req = 1'b0;
    logic [5:0] proc_gnt;
    logic       host_gnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbus_arbiter #(.NPROC(6)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_mode (rot_mode),
        .proc_req (proc_req),
        .lock     (lock),
        .busy     (busy),
        .host_req (host_req),
        .proc_gnt (proc_gnt),
        .host_gnt (host_gnt)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [5:0] eg, logic eh);
        n_chk++;
        if (proc_gnt !== eg || host_gnt !== eh) begin
            n_bad++;
            $display("FAIL %s: gnt=%b hgnt=%b expected gnt=%b hgnt=%b",
                     tag, proc_gnt, host_gnt, eg, eh);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R10 reset grants low", 6'b000000, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R10 idle after reset", 6'b000000, 1'b0);
    endtask

    task automatic t_fixed_and_park();
        rot_mode = 1'b0;
        proc_req = 6'b001100;
        step();
        chk("R10 first grant no gap / R2 lowest wins", 6'b000100, 1'b0);
        proc_req = 6'b001101;
        step();
        chk("R11 owner keeps bus", 6'b000100, 1'b0);
        proc_req = 6'b001000;
        step();
        chk("R5 gap cycle", 6'b000000, 1'b0);
        step();
        chk("R5 new owner after gap", 6'b001000, 1'b0);
        proc_req = 6'b000000;
        step();
        chk("R9 parked", 6'b001000, 1'b0);
        step();
        chk("R9 still parked", 6'b001000, 1'b0);
        proc_req = 6'b001000;
        step();
        chk("R9 re-request no gap", 6'b001000, 1'b0);
        proc_req = 6'b110010;
        step();
        chk("R5 gap before fixed winner", 6'b000000, 1'b0);
        step();
        chk("R2 fixed picks lowest", 6'b000010, 1'b0);
    endtask

    task automatic t_rotate();
        rot_mode = 1'b1;
        proc_req = 6'b100001;
        step();
        chk("R5 gap", 6'b000000, 1'b0);
        step();
        chk("R3 rotating skips past owner 1 to 5", 6'b100000, 1'b0);
        proc_req = 6'b001000;
        step();
        step();
        chk("R3 single requester", 6'b001000, 1'b0);
        rot_mode = 1'b0;
        proc_req = 6'b010010;
        step();
        step();
        chk("R4 mode change to fixed picks 1", 6'b000010, 1'b0);
    endtask

    task automatic t_lock_host();
        lock     = 1'b1;
        proc_req = 6'b000100;
        host_req = 1'b1;
        repeat (3) begin
            step();
            chk("R6 locked owner kept", 6'b000010, 1'b0);
        end
        lock = 1'b0;
        step();
        chk("R5 gap before host", 6'b000000, 1'b0);
        step();
        chk("R7 host outranks processor", 6'b000000, 1'b1);
        step();
        chk("R8 host holds", 6'b000000, 1'b1);
        host_req = 1'b0;
        step();
        chk("R8 host release gap", 6'b000000, 1'b0);
        step();
        chk("R5 processor after host", 6'b000100, 1'b0);
    endtask

    task automatic t_busy_host();
        busy     = 1'b1;
        host_req = 1'b1;
        repeat (2) begin
            step();
            chk("R7 host waits on busy owner", 6'b000100, 1'b0);
        end
        busy = 1'b0;
        step();
        chk("R7 gap after transfer end", 6'b000000, 1'b0);
        step();
        chk("R7 host granted while owner requests", 6'b000000, 1'b1);
        host_req = 1'b0;
        proc_req = 6'b000000;
        step();
        chk("R8 host drops to idle", 6'b000000, 1'b0);
        host_req = 1'b1;
        step();
        chk("R10 host from idle no gap", 6'b000000, 1'b1);
        host_req = 1'b0;
        step();
        chk("R8 host released", 6'b000000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fixed_and_park();
        t_rotate();
        t_lock_host();
        t_busy_host();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule